// File: doc/BRIEF.md
# Status Register with Watchdog Timer

This block is an 8-bit memory-mapped status/control register. Software reads it to learn whether any bus transfer is still outstanding, for example to find out when a pipelined write has drained. It also reads the live state of the address strobe and the two data strobes, which is useful for bus monitoring. The strobes are brought into the clock domain through two-flop synchronizers. The done bit follows the transfer-pending input in the same cycle.

The register also holds two control bits for a watchdog timer. One bit enables the watchdog. The other picks either a long or a short period. Both periods are parameters counted in pulses of a clock-enable tick, so a simulation can use small values. Every write to the register restarts the watchdog, whatever data is written. If no write arrives within the selected period, the block emits a one-cycle timeout pulse and the count starts again. A build parameter sends the pulse to either the interrupt output or the reset output.

Top module: `status_watchdog`

## Requirements
- R1: After reset the fast-select bit (bit 1) and the enable bit (bit 0) read 0, both timeout outputs are 0 and the watchdog is idle.
- R2: Read bit 7 (done) equals the inverse of `xferPending` in the same cycle, with no register on the path.
- R3: Read bits 6, 5 and 4 show `addrStrobe`, `dataStrobe0` and `dataStrobe1` after exactly two clock edges, through a two-flop synchronizer.
- R4: Read bits 3:2 are always 0. Write bits 7:2 change no readable state.
- R5: While bit 0 (enable) is 0, the counter is held clear and no timeout pulse is produced.
- R6: With bit 1 = 0, a timeout pulse appears on the clock edge that carries the SLOW_TICKS-th tick after the last restart. The pulse is exactly one cycle wide.
- R7: With bit 1 = 1, the period is FAST_TICKS ticks. A change of bit 1 takes effect from the restart caused by that same write.
- R8: Any write restarts the count from zero, including a write of data equal to the current contents.
- R9: After a pulse the counter reloads, so pulses repeat every selected period while no write arrives.
- R10: Clock edges without `tickEn` do not advance the count.
- R11: A write on the same edge as the final tick of a period wins. No pulse is produced and a full new period starts.
- R12: With TIMEOUT_AS_RESET = 0 (the default) the pulse goes to `timeoutIrq` only and `timeoutRst` stays 0. With 1, the pulse goes to `timeoutRst` only.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| tickEn | input | 1 | Clock-enable tick that advances the watchdog |
| wrEn | input | 1 | Register write strobe |
| wrData | input | 8 | Register write data |
| rdData | output | 8 | Register read value |
| xferPending | input | 1 | High while a bus transfer is outstanding |
| addrStrobe | input | 1 | Asynchronous address strobe monitor input |
| dataStrobe0 | input | 1 | Asynchronous data strobe 0 monitor input |
| dataStrobe1 | input | 1 | Asynchronous data strobe 1 monitor input |
| timeoutIrq | output | 1 | One-cycle watchdog timeout pulse, interrupt variant |
| timeoutRst | output | 1 | One-cycle watchdog timeout pulse, reset variant |

## Verification
A register write and the last tick of a watchdog period can land on the same clock edge. In that case the restart and the expiry compete for the counter. The bench provokes this by counting edges after a write, so that the next write lands exactly on the FAST_TICKS-th tick. It then judges that no pulse appears in that cycle and that the next pulse comes a full period after the second write. A second overlap, between the tick gate and the restart, is covered by holding `tickEn` low for a long stretch and then confirming the full period still runs.

// File: rtl/statwdog_pkg.sv
package statwdog_pkg;
  localparam int DONE_BIT  = 7;
  localparam int AS_BIT    = 6;
  localparam int DS0_BIT   = 5;
  localparam int DS1_BIT   = 4;
  localparam int FAST_BIT  = 1;
  localparam int EN_BIT    = 0;

  typedef struct packed {
    logic restart;
    logic fastSel;
    logic enable;
  } wdogCtl_t;
endpackage

// File: rtl/statwdog_ctrl.sv
module statwdog_ctrl
  import statwdog_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       wrEn,
  input  logic [7:0] wrData,
  output wdogCtl_t   ctl
);
  logic fastReg;
  logic enReg;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      fastReg <= 1'b0;
      enReg   <= 1'b0;
    end else if (wrEn) begin
      fastReg <= wrData[FAST_BIT];
      enReg   <= wrData[EN_BIT];
    end
  end

  always_comb begin
    ctl.restart = wrEn;
    ctl.fastSel = fastReg;
    ctl.enable  = enReg;
  end

  assert_write_loads_R7: assert property (@(posedge clk) disable iff (!rstN)
    wrEn |=> (fastReg == $past(wrData[FAST_BIT])) && (enReg == $past(wrData[EN_BIT])));
endmodule

// File: rtl/statwdog_dp.sv
module statwdog_dp
  import statwdog_pkg::*;
#(
  parameter int SLOW_TICKS  = 8000,
  parameter int FAST_TICKS  = 250,
  parameter int SYNC_STAGES = 2,
  parameter int NUM_STROBES = 3
)(
  input  logic                   clk,
  input  logic                   rstN,
  input  logic                   tickEn,
  input  wdogCtl_t               ctl,
  input  logic                   xferPending,
  input  logic [NUM_STROBES-1:0] strobesIn,
  output logic [7:0]             rdData,
  output logic                   expire
);
  localparam int MAX_TICKS = (SLOW_TICKS > FAST_TICKS) ? SLOW_TICKS : FAST_TICKS;
  localparam int CW        = $clog2(MAX_TICKS + 1);
  localparam logic [CW-1:0] SLOW_LAST = CW'(SLOW_TICKS - 1);
  localparam logic [CW-1:0] FAST_LAST = CW'(FAST_TICKS - 1);

  logic [NUM_STROBES-1:0] syncStage [SYNC_STAGES];
  logic [NUM_STROBES-1:0] strobesSync;

  genvar s;
  generate
    for (s = 0; s < SYNC_STAGES; s++) begin : gSync
      always_ff @(posedge clk) begin
        if (!rstN) syncStage[s] <= '0;
        else if (s == 0) syncStage[s] <= strobesIn;
        else syncStage[s] <= syncStage[(s == 0) ? 0 : s-1];
      end
    end
  endgenerate
  assign strobesSync = syncStage[SYNC_STAGES-1];

  logic [CW-1:0] cnt;
  logic [CW-1:0] lastCount;
  logic          atLast;

  assign lastCount = ctl.fastSel ? FAST_LAST : SLOW_LAST;
  assign atLast    = (cnt == lastCount);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cnt    <= '0;
      expire <= 1'b0;
    end else begin
      expire <= 1'b0;
      if (ctl.restart || !ctl.enable) begin
        cnt <= '0;
      end else if (tickEn) begin
        if (atLast) begin
          cnt    <= '0;
          expire <= 1'b1;
        end else begin
          cnt <= cnt + 1'b1;
        end
      end
    end
  end

  always_comb begin
    rdData           = 8'h00;
    rdData[DONE_BIT] = ~xferPending;
    rdData[AS_BIT]   = strobesSync[2];
    rdData[DS0_BIT]  = strobesSync[1];
    rdData[DS1_BIT]  = strobesSync[0];
    rdData[FAST_BIT] = ctl.fastSel;
    rdData[EN_BIT]   = ctl.enable;
  end

  assert_single_pulse_R6: assert property (@(posedge clk) disable iff (!rstN)
    expire |=> !expire);
  assert_disabled_silent_R5: assert property (@(posedge clk) disable iff (!rstN)
    !ctl.enable |=> !expire && (cnt == '0));
  assert_restart_clears_R8: assert property (@(posedge clk) disable iff (!rstN)
    ctl.restart |=> (cnt == '0) && !expire);
  assert_count_bounded_R9: assert property (@(posedge clk) disable iff (!rstN)
    cnt <= lastCount);
  assert_no_tick_hold_R10: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.enable && !ctl.restart && !tickEn) |=> $stable(cnt) && !expire);
endmodule

// File: rtl/status_watchdog.sv
module status_watchdog
  import statwdog_pkg::*;
#(
  parameter int SLOW_TICKS       = 8000,
  parameter int FAST_TICKS       = 250,
  parameter bit TIMEOUT_AS_RESET = 1'b0
)(
  input  logic       clk,
  input  logic       rstN,
  input  logic       tickEn,
  input  logic       wrEn,
  input  logic [7:0] wrData,
  output logic [7:0] rdData,
  input  logic       xferPending,
  input  logic       addrStrobe,
  input  logic       dataStrobe0,
  input  logic       dataStrobe1,
  output logic       timeoutIrq,
  output logic       timeoutRst
);
  wdogCtl_t ctl;
  logic     expire;

  statwdog_ctrl uCtrl (
    .clk    (clk),
    .rstN   (rstN),
    .wrEn   (wrEn),
    .wrData (wrData),
    .ctl    (ctl)
  );

  statwdog_dp #(
    .SLOW_TICKS  (SLOW_TICKS),
    .FAST_TICKS  (FAST_TICKS),
    .SYNC_STAGES (2),
    .NUM_STROBES (3)
  ) uDp (
    .clk         (clk),
    .rstN        (rstN),
    .tickEn      (tickEn),
    .ctl         (ctl),
    .xferPending (xferPending),
    .strobesIn   ({addrStrobe, dataStrobe0, dataStrobe1}),
    .rdData      (rdData),
    .expire      (expire)
  );

  generate
    if (TIMEOUT_AS_RESET) begin : gRst
      assign timeoutRst = expire;
      assign timeoutIrq = 1'b0;
    end else begin : gIrq
      assign timeoutIrq = expire;
      assign timeoutRst = 1'b0;
    end
  endgenerate

  initial begin
    assert (SLOW_TICKS >= 2 && FAST_TICKS >= 2)
      else $error("periods must be at least two ticks");
  end

  assert_one_output_R12: assert property (@(posedge clk) disable iff (!rstN)
    !(timeoutIrq && timeoutRst));
endmodule

// File: tb/status_watchdog_test.sv
`timescale 1ns/1ps
module status_watchdog_test;
  localparam int SLOW = 40;
  localparam int FAST = 10;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       tickEn = 1'b1;
  logic       wrEn = 1'b0;
  logic [7:0] wrData = 8'h00;
  logic [7:0] rdData;
  logic       xferPending = 1'b0;
  logic       addrStrobe = 1'b0;
  logic       dataStrobe0 = 1'b0;
  logic       dataStrobe1 = 1'b0;
  logic       timeoutIrq;
  logic       timeoutRst;

  int checks = 0;
  int fails = 0;
  int rstSeen = 0;

  always #4 clk = ~clk;

  status_watchdog #(.SLOW_TICKS(SLOW), .FAST_TICKS(FAST)) uut (
    .clk(clk), .rstN(rstN), .tickEn(tickEn), .wrEn(wrEn), .wrData(wrData),
    .rdData(rdData), .xferPending(xferPending), .addrStrobe(addrStrobe),
    .dataStrobe0(dataStrobe0), .dataStrobe1(dataStrobe1),
    .timeoutIrq(timeoutIrq), .timeoutRst(timeoutRst)
  );

  always @(negedge clk) if (rstN && timeoutRst) rstSeen++;

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d (0x%0h) expected %0d (0x%0h)", req, act, act, exp, exp);
    end
  endtask

  task automatic doWrite(input logic [7:0] d);
    @(negedge clk); wrEn = 1'b1; wrData = d;
    @(negedge clk); wrEn = 1'b0;
  endtask

  // edges until a pulse is seen, sampled just after each edge; limit+1 if none
  task automatic edgesToPulse(input int limit, output int n);
    n = limit + 1;
    for (int i = 1; i <= limit; i++) begin
      @(posedge clk); #1;
      if (timeoutIrq) begin n = i; break; end
    end
  endtask

  task automatic testReset();
    chk("R1 reset read value", rdData, 8'h80);
    chk("R1 irq low after reset", timeoutIrq, 0);
    chk("R1 rst low after reset", timeoutRst, 0);
  endtask

  task automatic testDone();
    @(negedge clk); xferPending = 1'b1; #1;
    chk("R2 done low while pending", rdData[7], 0);
    @(negedge clk); xferPending = 1'b0; #1;
    chk("R2 done high when idle", rdData[7], 1);
  endtask

  task automatic testStrobes();
    @(negedge clk); addrStrobe = 1'b1; dataStrobe1 = 1'b1;
    @(posedge clk); #1;
    chk("R3 strobes not visible after one edge", rdData[6:4], 3'b000);
    @(posedge clk); #1;
    chk("R3 strobes visible after two edges", rdData[6:4], 3'b101);
    @(negedge clk); addrStrobe = 1'b0; dataStrobe0 = 1'b1; dataStrobe1 = 1'b0;
    repeat (2) @(posedge clk); #1;
    chk("R3 second strobe pattern", rdData[6:4], 3'b010);
    @(negedge clk); dataStrobe0 = 1'b0;
    repeat (2) @(posedge clk); #1;
  endtask

  task automatic testReserved();
    int n;
    doWrite(8'hFC); #1;
    chk("R4 reserved and status bits ignore write", rdData, 8'h80);
    edgesToPulse(3 * SLOW, n);
    chk("R5 disabled watchdog never fires", n, 3 * SLOW + 1);
  endtask

  task automatic testSlow();
    int n;
    doWrite(8'h01); #1;
    chk("R6 slow mode readback", rdData[1:0], 2'b01);
    edgesToPulse(2 * SLOW, n);
    chk("R6 slow period", n, SLOW);
    @(posedge clk); #1;
    chk("R6 pulse one cycle wide", timeoutIrq, 0);
  endtask

  task automatic testFastReload();
    int n;
    doWrite(8'h03); #1;
    edgesToPulse(2 * FAST, n);
    chk("R7 fast period from same write", n, FAST);
    edgesToPulse(2 * FAST, n);
    chk("R9 reload gives next pulse one period later", n, FAST);
  endtask

  task automatic testRewrite();
    int n;
    doWrite(8'h03);
    repeat (6) @(negedge clk);
    doWrite(8'h03); #1;
    edgesToPulse(2 * FAST, n);
    chk("R8 same-data write restarts count", n, FAST);
  endtask

  task automatic testTickGate();
    int n;
    doWrite(8'h03);
    tickEn = 1'b0;
    edgesToPulse(5 * FAST, n);
    chk("R10 no pulse without ticks", n, 5 * FAST + 1);
    @(negedge clk); tickEn = 1'b1;
    edgesToPulse(2 * FAST, n);
    chk("R10 full period after ticks resume", n, FAST);
  endtask

  task automatic testCollide();
    int n;
    doWrite(8'h03);
    repeat (FAST - 2) @(negedge clk);
    doWrite(8'h03); // write edge is the FAST-th tick edge
    #1;
    chk("R11 write on final tick suppresses pulse", timeoutIrq, 0);
    edgesToPulse(2 * FAST, n);
    chk("R11 full period after colliding write", n, FAST);
  endtask

  initial begin
    #1_000_000;
    fails++; checks++;
    $display("FAIL watchdog: bench hung, actual running expected finished");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    #1;
    testReset();
    testDone();
    testStrobes();
    testReserved();
    testSlow();
    testFastReload();
    testRewrite();
    testTickGate();
    testCollide();
    chk("R12 reset output stays low in interrupt variant", rstSeen, 0);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule